// File: doc/BRIEF.md
# Instruction Fetch Translation Buffer

This block turns a 64-bit virtual fetch address into a physical address for the instruction side of a processor core. It holds a set of translation entries, all compared against every request at the same time. Each entry pairs a tag with a translation word. The tag holds the virtual page number and an address-space context. The translation word holds a valid flag, a page-size code, a privileged-page flag and the physical frame. Because the page size is chosen per entry, the span of address bits each entry compares depends on that entry.

A lookup is requested with `req_i`. The outcome is registered and appears one cycle later as exactly one of three results: an executable translation, a miss, or a protection fault. A miss means no entry matched. A protection fault means an entry matched but the access was not allowed. Protection faults are recorded in a small sticky status register. That register notes overflow when a second fault lands before software has read and cleared it. Entries are loaded one per cycle through a write port. When translation is turned off, fetch addresses pass straight through.

Top module: `fetch_itlb`

## Requirements
- R1: The block holds 64 entries, all compared on every lookup. Driving `wr_en_i` with an index loads that entry's tag and translation word at the next clock edge. A lookup in any later cycle sees the new contents, and rewriting an entry replaces its old mapping.
- R2: Translation-word bits 62:61 give the page size, and with it the number of low address bits left out of the compare: code 0 is 8 KiB (13 bits), 1 is 64 KiB (16), 2 is 512 KiB (19), 3 is 4 MiB (22).
- R3: An entry matches only when two conditions hold. Tag bits 12:0 must equal `ctx_i`. The virtual address, with the page-size bits cleared, must equal the tag with bits 12:0 cleared.
- R4: When more than one entry matches, the entry with the lowest index supplies the result.
- R5: A match on an entry whose translation-word bit 63 (valid) is 0 reports `prot_fault_o`, not a miss.
- R6: Translation-word bit 2 marks a privileged page. A match on such a page with `user_i` high gives a protection fault. With `user_i` low the fetch is allowed.
- R7: On an allowed match, `pa_o` is the sum of two terms. The first is the translation word ANDed with the page mask and with field 0x1FF_FFFF_F000 (bits 40:12). The second is the virtual address ANDed with the inverted page mask and with the same field. So `pa_o` bits 11:0 and 63:41 are zero, and `exec_o` is 1.
- R8: With `xlate_en_i` low, a lookup returns `pa_o` equal to `va_i` with `exec_o` high, and never misses or faults.
- R9: When no entry matches, `miss_o` is reported, and the status register is left as it was. Each response asserts exactly one of `exec_o`, `miss_o`, `prot_fault_o`.
- R10: The status register `fsr_o` is a 4-bit code. On a protection fault, if its value is nonzero, it is first replaced by 4'b0010 to mark overflow. It is then ORed with 4'b0001 and with the user flag in bit 3.
- R11: A pulse on `fsr_rd_i` clears the status register at the next edge. A fault in the same cycle is recorded against the cleared value, so no overflow is marked.
- R12: `rsp_valid_o` and the result appear on the cycle after `req_i`, and back-to-back requests give one response per cycle. After reset there is no response and `fsr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Lookup request |
| va_i | input | 64 | Virtual fetch address |
| user_i | input | 1 | Access made in user mode |
| xlate_en_i | input | 1 | Translation enable; low passes addresses through |
| ctx_i | input | 13 | Current context |
| wr_en_i | input | 1 | Load an entry |
| wr_idx_i | input | 6 | Entry index to load |
| wr_tag_i | input | 64 | Tag: page number in 63:13, context in 12:0 |
| wr_tte_i | input | 64 | Translation word: valid 63, size 62:61, privileged 2, frame in 40:13 |
| fsr_rd_i | input | 1 | Status read strobe; clears the status |
| rsp_valid_o | output | 1 | Registered result valid |
| pa_o | output | 64 | Physical address |
| exec_o | output | 1 | Fetch allowed |
| miss_o | output | 1 | No matching entry |
| prot_fault_o | output | 1 | Match, but access refused |
| fsr_o | output | 4 | Fault status register |

## Verification
The checker properties depend on a few things about the inputs. `req_i` must be low while reset is held, so the first registered response is tied to a real request. The status strobe is a single-cycle pulse that the properties compare against the status from one edge earlier. The bench issues lookups only on cycles without a write, so no property has to settle which wins when a write and a lookup hit the same entry. Every lookup uses a nonzero context, which keeps the all-zero entries left by reset from matching unintentionally.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int unsigned ADDR_W      = 64;
  localparam int unsigned CTX_W       = 13;
  localparam int unsigned VALID_BIT   = 63;
  localparam int unsigned SZ_HI       = 62;
  localparam int unsigned SZ_LO       = 61;
  localparam int unsigned PRIV_BIT    = 2;
  localparam int unsigned BASE_SHIFT  = 13;
  localparam int unsigned SHIFT_STEP  = 3;
  localparam int unsigned FRAME_HI    = 40;
  localparam int unsigned FRAME_LO    = 12;
  localparam int unsigned FSR_W       = 4;

  localparam logic [ADDR_W-1:0] CTX_FIELD =
    (ADDR_W'(1) << CTX_W) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] FRAME_FIELD =
    ((ADDR_W'(1) << (FRAME_HI + 1)) - ADDR_W'(1)) &
    ~((ADDR_W'(1) << FRAME_LO) - ADDR_W'(1));

  typedef enum logic [1:0] {
    RES_EXEC  = 2'd0,
    RES_MISS  = 2'd1,
    RES_FAULT = 2'd2
  } xlate_res_e;

  // Mask that keeps the page-number bits for a size code
  function automatic logic [ADDR_W-1:0] page_mask(input logic [1:0] code);
    int unsigned sh;
    sh = BASE_SHIFT + SHIFT_STEP * int'(code);
    return ~((ADDR_W'(1) << sh) - ADDR_W'(1));
  endfunction
endpackage

// File: rtl/itlb_entry_store.sv
module itlb_entry_store
  import itlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_en_i,
  input  logic [IDX_W-1:0]                    wr_idx_i,
  input  logic [ADDR_W-1:0]                   wr_tag_i,
  input  logic [ADDR_W-1:0]                   wr_tte_i,
  output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  tag_o,
  output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  tte_o
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_o[g] <= '0;
        tte_o[g] <= '0;
      end else if (sel) begin
        tag_o[g] <= wr_tag_i;
        tte_o[g] <= wr_tte_i;
      end
    end
  end
endmodule

// File: rtl/itlb_match.sv
module itlb_match
  import itlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64
) (
  input  logic [ADDR_W-1:0]                   va_i,
  input  logic [CTX_W-1:0]                    ctx_i,
  input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  tag_i,
  input  logic [NUM_ENTRIES-1:0][1:0]         size_i,
  output logic [NUM_ENTRIES-1:0]              hit_o
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    logic [ADDR_W-1:0] msk;
    logic              ctx_eq;
    logic              page_eq;
    assign msk     = page_mask(size_i[g]);
    assign ctx_eq  = (tag_i[g][CTX_W-1:0] == ctx_i);
    // tag bits between the context and the page boundary must be zero to hit
    assign page_eq = ((va_i & msk) == (tag_i[g] & ~CTX_FIELD));
    assign hit_o[g] = ctx_eq && page_eq;
  end
endmodule

// File: rtl/itlb_prio_enc.sv
module itlb_prio_enc #(
  parameter int unsigned NUM_ENTRIES = 64,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES-1:0] req_i,
  output logic [IDX_W-1:0]       idx_o,
  output logic                   any_o
);
  // scan downward so the lowest set bit is the last one kept
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/itlb_fault_status.sv
module itlb_fault_status
  import itlb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  input  logic             user_i,
  input  logic             rd_i,
  output logic [FSR_W-1:0] fsr_o
);
  logic [FSR_W-1:0] base, nxt;

  always_comb begin
    base = rd_i ? '0 : fsr_o;
    nxt  = base;
    if (fault_i) begin
      if (base != '0) nxt = FSR_W'(2);
      nxt = nxt | {user_i, 3'b001};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fsr_o <= '0;
    else         fsr_o <= nxt;
  end
endmodule

// File: rtl/fetch_itlb.sv
module fetch_itlb
  import itlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_i,
  input  logic [63:0]                      va_i,
  input  logic                             user_i,
  input  logic                             xlate_en_i,
  input  logic [12:0]                      ctx_i,
  input  logic                             wr_en_i,
  input  logic [$clog2(NUM_ENTRIES)-1:0]   wr_idx_i,
  input  logic [63:0]                      wr_tag_i,
  input  logic [63:0]                      wr_tte_i,
  input  logic                             fsr_rd_i,
  output logic                             rsp_valid_o,
  output logic [63:0]                      pa_o,
  output logic                             exec_o,
  output logic                             miss_o,
  output logic                             prot_fault_o,
  output logic [3:0]                       fsr_o
);
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES);

  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] tag_arr, tte_arr;
  logic [NUM_ENTRIES-1:0][1:0]        size_arr;
  logic [NUM_ENTRIES-1:0]             hit_vec;
  logic [IDX_W-1:0]                   sel_idx;
  logic                               any_hit;
  logic [ADDR_W-1:0]                  sel_tte, sel_mask, pa_d;
  logic                               refuse;
  xlate_res_e                         res_d;
  logic                               fault_now;

  itlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_tag_i (wr_tag_i),
    .wr_tte_i (wr_tte_i),
    .tag_o    (tag_arr),
    .tte_o    (tte_arr)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_sz
    assign size_arr[g] = tte_arr[g][SZ_HI:SZ_LO];
  end

  itlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) i_match (
    .va_i   (va_i),
    .ctx_i  (ctx_i),
    .tag_i  (tag_arr),
    .size_i (size_arr),
    .hit_o  (hit_vec)
  );

  itlb_prio_enc #(.NUM_ENTRIES(NUM_ENTRIES)) i_prio (
    .req_i (hit_vec),
    .idx_o (sel_idx),
    .any_o (any_hit)
  );

  assign sel_tte  = tte_arr[sel_idx];
  assign sel_mask = page_mask(sel_tte[SZ_HI:SZ_LO]);
  assign refuse   = !sel_tte[VALID_BIT] || (sel_tte[PRIV_BIT] && user_i);

  always_comb begin
    if (!xlate_en_i) begin
      res_d = RES_EXEC;
      pa_d  = va_i;
    end else begin
      pa_d = (sel_tte & sel_mask & FRAME_FIELD) + (va_i & ~sel_mask & FRAME_FIELD);
      if (!any_hit)    res_d = RES_MISS;
      else if (refuse) res_d = RES_FAULT;
      else             res_d = RES_EXEC;
    end
  end

  assign fault_now = req_i && (res_d == RES_FAULT);

  itlb_fault_status i_fsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fault_i (fault_now),
    .user_i  (user_i),
    .rd_i    (fsr_rd_i),
    .fsr_o   (fsr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      pa_o         <= '0;
      exec_o       <= 1'b0;
      miss_o       <= 1'b0;
      prot_fault_o <= 1'b0;
    end else begin
      rsp_valid_o  <= req_i;
      exec_o       <= req_i && (res_d == RES_EXEC);
      miss_o       <= req_i && (res_d == RES_MISS);
      prot_fault_o <= req_i && (res_d == RES_FAULT);
      if (req_i) pa_o <= (res_d == RES_EXEC) ? pa_d : '0;
    end
  end
endmodule

// File: rtl/fetch_itlb_chk.sv
module fetch_itlb_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic [63:0] va_i,
  input logic        user_i,
  input logic        xlate_en_i,
  input logic        fsr_rd_i,
  input logic        rsp_valid_o,
  input logic [63:0] pa_o,
  input logic        exec_o,
  input logic        miss_o,
  input logic        prot_fault_o,
  input logic [3:0]  fsr_o
);
  a_r12_rsp_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_i));

  a_r12_no_stray_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(exec_o || miss_o || prot_fault_o));

  a_r9_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({exec_o, miss_o, prot_fault_o}) == 1);

  a_r8_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !$past(xlate_en_i)) |-> (exec_o && pa_o == $past(va_i)));

  a_r7_frame_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && exec_o && $past(xlate_en_i)) |->
      (pa_o[11:0] == 12'h0 && pa_o[63:41] == '0));

  a_r10_fault_logged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && prot_fault_o) |-> (fsr_o[0] && fsr_o[3] == $past(user_i)));

  a_r10_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && prot_fault_o && $past(fsr_o) != 4'h0 && !$past(fsr_rd_i))
      |-> fsr_o[1]);

  a_r9_fsr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && prot_fault_o) |->
      (fsr_o == ($past(fsr_rd_i) ? 4'h0 : $past(fsr_o))));

  a_r11_clear_no_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && prot_fault_o && $past(fsr_rd_i)) |-> !fsr_o[1]);
endmodule

bind fetch_itlb fetch_itlb_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .va_i         (va_i),
  .user_i       (user_i),
  .xlate_en_i   (xlate_en_i),
  .fsr_rd_i     (fsr_rd_i),
  .rsp_valid_o  (rsp_valid_o),
  .pa_o         (pa_o),
  .exec_o       (exec_o),
  .miss_o       (miss_o),
  .prot_fault_o (prot_fault_o),
  .fsr_o        (fsr_o)
);

// File: tb/test_fetch_itlb.sv
`timescale 1ns/1ps
module test_fetch_itlb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [63:0] va_i = '0;
  logic        user_i = 1'b0;
  logic        xlate_en_i = 1'b0;
  logic [12:0] ctx_i = '0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  wr_idx_i = '0;
  logic [63:0] wr_tag_i = '0;
  logic [63:0] wr_tte_i = '0;
  logic        fsr_rd_i = 1'b0;
  logic        rsp_valid_o;
  logic [63:0] pa_o;
  logic        exec_o, miss_o, prot_fault_o;
  logic [3:0]  fsr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  fetch_itlb i_fetch_itlb (.*);

  typedef struct {
    logic [63:0] pa;
    logic        ex, ms, pf;
    logic [3:0]  fsr;
    string       rq;
  } exp_t;
  exp_t sb[$];

  logic [63:0] m_tag [64];
  logic [63:0] m_tte [64];
  logic [3:0]  m_fsr = '0;

  localparam logic [63:0] FRAME = 64'h0000_01FF_FFFF_F000;

  function automatic logic [63:0] size_mask(input logic [1:0] c);
    case (c)
      2'd0: return ~64'h1FFF;
      2'd1: return ~64'hFFFF;
      2'd2: return ~64'h7FFFF;
      default: return ~64'h3FFFFF;
    endcase
  endfunction

  function automatic logic [63:0] mk_tte(input logic v, input logic [1:0] sz,
                                         input logic pv, input logic [63:0] frame);
    return ({v, sz, 61'h0}) | (frame & ~64'h4) | {61'h0, pv, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic put_entry(input int idx, input logic [63:0] tag, input logic [63:0] tte);
    @(negedge clk_i);
    req_i = 1'b0; fsr_rd_i = 1'b0;
    wr_en_i = 1'b1; wr_idx_i = 6'(idx); wr_tag_i = tag; wr_tte_i = tte;
    m_tag[idx] = tag; m_tte[idx] = tte;
  endtask

  task automatic lookup(input logic [63:0] va, input logic [12:0] ctx, input logic usr,
                        input logic en, input logic rd, input string rq);
    exp_t e;
    int   w;
    logic [63:0] mk;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    req_i = 1'b1; va_i = va; ctx_i = ctx; user_i = usr; xlate_en_i = en; fsr_rd_i = rd;
    e.rq = rq; e.ex = 1'b0; e.ms = 1'b0; e.pf = 1'b0; e.pa = '0;
    if (rd) m_fsr = '0;
    if (!en) begin
      e.ex = 1'b1; e.pa = va;
    end else begin
      w = -1;
      for (int i = 0; i < 64; i++) begin
        mk = size_mask(m_tte[i][62:61]);
        if (w < 0 && m_tag[i][12:0] == ctx && (va & mk) == (m_tag[i] & ~64'h1FFF)) w = i;
      end
      if (w < 0) e.ms = 1'b1;
      else if (!m_tte[w][63] || (m_tte[w][2] && usr)) begin
        e.pf = 1'b1;
        if (m_fsr != 4'h0) m_fsr = 4'h2;
        m_fsr = m_fsr | {usr, 3'b001};
      end else begin
        mk = size_mask(m_tte[w][62:61]);
        e.ex = 1'b1;
        e.pa = (m_tte[w] & mk & FRAME) + (va & ~mk & FRAME);
      end
    end
    e.fsr = m_fsr;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_i = 1'b0; wr_en_i = 1'b0; fsr_rd_i = 1'b0;
  endtask

  task automatic read_fsr(input string rq);
    @(negedge clk_i);
    req_i = 1'b0; wr_en_i = 1'b0;
    chk(fsr_o == m_fsr, rq, "fsr before read", 64'(fsr_o), 64'(m_fsr));
    fsr_rd_i = 1'b1;
    m_fsr = '0;
    idle();
    chk(fsr_o == 4'h0, rq, "fsr after read", 64'(fsr_o), 64'h0);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R12", "response with nothing expected", 64'(rsp_valid_o), 64'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(pa_o == e.pa && exec_o == e.ex && miss_o == e.ms &&
            prot_fault_o == e.pf && fsr_o == e.fsr, e.rq,
            "pa/{ex,ms,pf,fsr}",
            {pa_o[55:0], exec_o, miss_o, prot_fault_o, 1'b0, fsr_o},
            {e.pa[55:0], e.ex, e.ms, e.pf, 1'b0, e.fsr});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_tag[i] = '0; m_tte[i] = '0; end
    repeat (3) @(negedge clk_i);
    chk(rsp_valid_o == 1'b0 && fsr_o == 4'h0, "R12", "reset state",
        {59'h0, rsp_valid_o, fsr_o}, 64'h0);
    rst_ni = 1'b1;
    idle();

    // R8 bypass
    lookup(64'h1234_5678_9ABC_DEF1, 13'd7, 1'b0, 1'b0, 1'b0, "R8 bypass");
    // R1 R2 R3 entry loads, one per size
    put_entry(3,  64'h0000_0040_0000_2000 | 64'd7, mk_tte(1, 2'd0, 0, 64'h0004_0123_4568_E000));
    put_entry(10, 64'h0000_0012_3450_0000 | 64'd7, mk_tte(1, 2'd1, 0, 64'h0000_00AB_CDE0_0000));
    put_entry(20, 64'h0000_7FFF_FF80_0000 | 64'd7, mk_tte(1, 2'd2, 0, 64'h0000_0155_5500_0000));
    put_entry(63, 64'hFFFF_FFFF_FFC0_0000 | 64'd7, mk_tte(1, 2'd3, 0, 64'h0000_01C0_0040_0000));
    lookup(64'h0000_0040_0000_3ABC, 13'd7, 1'b0, 1'b1, 1'b0, "R2 R7 8K hit");
    lookup(64'h0000_0040_0000_3ABC, 13'd8, 1'b0, 1'b1, 1'b0, "R3 ctx mismatch miss");
    lookup(64'h0000_0040_0000_4000, 13'd7, 1'b0, 1'b1, 1'b0, "R3 next page miss");
    lookup(64'h0000_0012_3450_F123, 13'd7, 1'b0, 1'b1, 1'b0, "R2 64K hit");
    lookup(64'h0000_7FFF_FF87_FFF8, 13'd7, 1'b0, 1'b1, 1'b0, "R2 512K hit");
    lookup(64'hFFFF_FFFF_FFC3_1234, 13'd7, 1'b0, 1'b1, 1'b0, "R1 R2 4M hit last entry");
    lookup(64'hFFFF_FFFF_FF80_0000, 13'd7, 1'b0, 1'b1, 1'b0, "R9 outside 4M miss");
    // R4 priority
    put_entry(40, 64'h0000_0000_1000_0000 | 64'd2, mk_tte(1, 2'd0, 0, 64'h0000_0000_4444_0000));
    put_entry(30, 64'h0000_0000_1000_0000 | 64'd2, mk_tte(1, 2'd0, 0, 64'h0000_0000_3333_0000));
    lookup(64'h0000_0000_1000_0010, 13'd2, 1'b0, 1'b1, 1'b0, "R4 lowest index wins");
    put_entry(30, 64'h0000_0000_1000_0000 | 64'd3, mk_tte(1, 2'd0, 0, 64'h0000_0000_3333_0000));
    lookup(64'h0000_0000_1000_0010, 13'd2, 1'b0, 1'b1, 1'b0, "R1 R4 rewrite exposes entry 40");
    // R5 R6 R10 faults
    put_entry(5, 64'h0000_0000_2000_0000 | 64'd2, mk_tte(0, 2'd0, 0, 64'h0000_0000_5555_0000));
    put_entry(6, 64'h0000_0000_3000_0000 | 64'd2, mk_tte(1, 2'd0, 1, 64'h0000_0000_6666_0000));
    lookup(64'h0000_0000_2000_0100, 13'd2, 1'b0, 1'b1, 1'b0, "R5 R10 invalid entry fault");
    lookup(64'h0000_0000_3000_0100, 13'd2, 1'b1, 1'b1, 1'b0, "R6 R10 user on priv page overflow");
    lookup(64'h0000_0000_3000_0100, 13'd2, 1'b0, 1'b1, 1'b0, "R6 priv access allowed");
    lookup(64'h0000_0000_7000_0000, 13'd2, 1'b1, 1'b1, 1'b0, "R9 miss keeps fsr");
    idle();
    read_fsr("R11");
    // R11 read together with fault
    lookup(64'h0000_0000_2000_0000, 13'd2, 1'b0, 1'b1, 1'b0, "R10 first fault");
    lookup(64'h0000_0000_3000_0000, 13'd2, 1'b1, 1'b1, 1'b1, "R11 read with fault no overflow");
    lookup(64'h0000_0000_2000_0000, 13'd2, 1'b0, 1'b1, 1'b0, "R10 second fault overflow");
    lookup(64'h0000_0000_3000_0000, 13'd2, 1'b1, 1'b0, 1'b0, "R8 bypass ignores priv page");
    idle();
    idle();
    chk(sb.size() == 0, "R12", "all responses seen", 64'(sb.size()), 64'h0);
    read_fsr("R11");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule